// File: doc/BRIEF.md
# Configurable Instruction Cache Controller

This block is a read-only instruction cache between a fetch stage and instruction memory. It holds eight lines of 16 bytes, each with four 32-bit instructions. The fetch stage presents a byte address with a valid flag. On a hit the instruction comes out of a register one cycle later. On a miss the controller raises a stall, asks memory for the whole line, and then writes the line into the array. After a fixed penalty it delivers the requested word in the same cycle that the line becomes valid.

A build-time parameter chooses between two organisations of the same eight lines. In the direct-mapped form, address bits [6:4] select the line. In the two-way form there are four sets, selected by bits [5:4], and each set keeps one recency bit to choose its victim. Every delivered instruction comes with exactly one pulse, either hit or miss, so that a performance counter can compute miss rates.

The handshake is simple. A fetch is accepted on any clock edge where `fetch_valid_i` is high and `stall_o` is low. Each accepted fetch produces exactly one instruction on the next cycle. While `stall_o` is high, the fetch stage keeps its request unchanged.

Top module: `icache_ctrl`

## Requirements
- R1: After a synchronous reset the outputs `instr_valid_o`, `hit_pulse_o` and `miss_pulse_o` are low and every line is invalid, so the first fetch to any line misses.
- R2: A fetch that hits keeps `stall_o` low in the cycle it is presented. The instruction appears with `instr_valid_o` on the next cycle.
- R3: A fetch that misses holds `stall_o` high for exactly MISS_PENALTY cycles, starting with the cycle it is presented. It is accepted in the cycle after those, so delivery comes MISS_PENALTY cycles later than for a hit.
- R4: During a refill `mem_rd_o` is high and `mem_addr_o` carries the fetch address with its low four bits cleared. Memory word i (byte offset 4*i) lies in bits [32*i+31:32*i] of `mem_line_i`. The delivered instruction is the word selected by address bits [3:2].
- R5: A fetch to any word of a line that is already resident hits, including a line that was first loaded through a fetch to the middle of the line.
- R6: With WAYS=1 the line is chosen by address bits [6:4]. Two lines that share those bits evict each other. Lines with other index bits are not affected.
- R7: With WAYS=2 the set is chosen by address bits [5:4]. Two lines that share a set can both be resident at the same time.
- R8: With WAYS=2, a miss into a full set replaces the way that was used less recently. Both hits and refills count as uses.
- R9: With WAYS=2, a miss fills an invalid way of the set before it evicts any valid way.
- R10: Each delivered instruction comes with exactly one pulse: `miss_pulse_o` if the fetch needed a refill, `hit_pulse_o` otherwise. No pulse appears without a delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Fetch request present |
| fetch_addr_i | input | ADDR_W | Byte address of the instruction |
| stall_o | output | 1 | Request not accepted this cycle; hold it |
| instr_valid_o | output | 1 | Instruction delivered this cycle |
| instr_o | output | INSTR_W | Delivered instruction |
| hit_pulse_o | output | 1 | Delivered fetch was a hit |
| miss_pulse_o | output | 1 | Delivered fetch needed a refill |
| mem_rd_o | output | 1 | Line read request to memory |
| mem_addr_o | output | ADDR_W | Line-aligned byte address for memory |
| mem_line_i | input | LINE_BYTES*8 | Full line returned by memory |

## Verification
Both organisations are built side by side and driven with address streams modelled on a small loop. The first stream starts in the middle of a line and then touches the neighbouring words, which separates offset handling from index handling. A second stream alternates three lines that share index bits [6:4]. In the direct-mapped build every access in it misses, while in the two-way build the first two lines stay resident; this shows the difference between the set-index bit fields and the fill-invalid-way rule. A third stream reorders hits among three lines of one set, so that only a correct recency choice gives the expected pattern of hits and misses. Stall lengths, delivered words and pulse kinds are checked against the values derived from the requirements, and a mid-run reset confirms that all lines become invalid.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_WAIT = 1'b1
  } fill_state_e;
endpackage

// File: rtl/icache_line_ram.sv
module icache_line_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 128,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int WAYS  = 1,
  parameter int SETS  = 8,
  parameter int SET_W = 3,
  parameter int TAG_W = 25,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAY_W-1:0] victim,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             use_en,
  input  logic [SET_W-1:0] use_set,
  input  logic [WAY_W-1:0] use_way
);
  logic [WAYS-1:0] inv_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;
    logic             wr_here;

    assign wr_here = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (wr_here) tag_mem[wr_set] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (rst)          vld_q         <= '0;
      else if (wr_here) vld_q[wr_set] <= 1'b1;
    end

    assign hit_vec[w] = vld_q[lk_set] && (tag_mem[lk_set] == lk_tag);
    assign inv_vec[w] = !vld_q[lk_set];
  end

  if (WAYS == 2) begin : g_lru
    // one bit per set naming the way to replace next
    logic [SETS-1:0] lru_q;
    always_ff @(posedge clk) begin
      if (rst)         lru_q          <= '0;
      else if (use_en) lru_q[use_set] <= ~use_way[0];
    end
    assign victim = inv_vec[0] ? 1'b0 : (inv_vec[1] ? 1'b1 : lru_q[lk_set]);
  end else begin : g_direct
    logic unused_recency;
    assign unused_recency = ^{use_en, use_set, use_way, inv_vec};
    assign victim = '0;
  end

  // R7: a tag can live in only one way of a set
  a_r7_single_way_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  initial begin
    a_r7_ways_supported: assert (WAYS == 1 || WAYS == 2);
  end
endmodule

// File: rtl/icache_fill_ctl.sv
module icache_fill_ctl
  import icache_pkg::*;
#(
  parameter int PENALTY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CNT_W = (PENALTY > 1) ? $clog2(PENALTY) : 1;

  fill_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FILL_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        FILL_IDLE: if (start) begin
          state_q <= FILL_WAIT;
          cnt_q   <= '0;
        end
        FILL_WAIT: if (last) state_q <= FILL_IDLE;
                   else      cnt_q   <= cnt_q + 1'b1;
        default:   state_q <= FILL_IDLE;
      endcase
    end
  end

  assign busy = (state_q == FILL_WAIT);
  assign last = busy && (cnt_q == CNT_W'(PENALTY - 1));

  // R3: refill runs without interruption and then returns to idle
  a_r3_fill_continues: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);
  a_r3_fill_exits: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= CNT_W'(PENALTY - 1)));
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl #(
  parameter int ADDR_W       = 32,
  parameter int INSTR_W      = 32,
  parameter int LINES        = 8,
  parameter int LINE_BYTES   = 16,
  parameter int WAYS         = 1,
  parameter int MISS_PENALTY = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fetch_valid_i,
  input  logic [ADDR_W-1:0]       fetch_addr_i,
  output logic                    stall_o,
  output logic                    instr_valid_o,
  output logic [INSTR_W-1:0]      instr_o,
  output logic                    hit_pulse_o,
  output logic                    miss_pulse_o,
  output logic                    mem_rd_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic [LINE_BYTES*8-1:0] mem_line_i
);
  localparam int SETS   = LINES / WAYS;
  localparam int SET_W  = $clog2(SETS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_W / INSTR_W;
  localparam int BSEL_W = $clog2(INSTR_W / 8);
  localparam int WSEL_W = $clog2(WORDS);

  logic [SET_W-1:0]        set_idx;
  logic [TAG_W-1:0]        tag;
  logic [WSEL_W-1:0]       wsel;
  logic [WAYS-1:0]         hit_vec;
  logic                    any_hit;
  logic [WAY_W-1:0]        victim, hit_way, use_way;
  logic                    busy, last, start, accept;
  logic [WAY_W-1:0]        miss_way_q;
  logic [ADDR_W-OFF_W-1:0] line_base_q;
  logic [LINE_W-1:0]       rd_line [WAYS];
  logic [LINE_W-1:0]       hit_line, src_line;
  logic [INSTR_W-1:0]      word;
  logic                    unused_low;

  assign set_idx    = fetch_addr_i[OFF_W +: SET_W];
  assign tag        = fetch_addr_i[ADDR_W-1 -: TAG_W];
  assign wsel       = fetch_addr_i[BSEL_W +: WSEL_W];
  assign unused_low = ^fetch_addr_i[BSEL_W-1:0];
  assign any_hit    = |hit_vec;

  assign start   = fetch_valid_i && !busy && !any_hit;
  assign stall_o = busy ? !last : (fetch_valid_i && !any_hit);
  assign accept  = fetch_valid_i && !stall_o;

  icache_fill_ctl #(.PENALTY(MISS_PENALTY)) u_fill (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .last(last)
  );

  always_ff @(posedge clk) begin
    if (start) begin
      miss_way_q  <= victim;
      line_base_q <= fetch_addr_i[ADDR_W-1:OFF_W];
    end
  end

  assign mem_rd_o   = busy;
  assign mem_addr_o = {line_base_q, {OFF_W{1'b0}}};

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign use_way = busy ? miss_way_q : hit_way;

  icache_tags #(
    .WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst(rst),
    .lk_set(set_idx), .lk_tag(tag), .hit_vec(hit_vec), .victim(victim),
    .wr_en(last), .wr_set(line_base_q[SET_W-1:0]), .wr_way(miss_way_q),
    .wr_tag(line_base_q[ADDR_W-OFF_W-1:SET_W]),
    .use_en(accept), .use_set(set_idx), .use_way(use_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_data
    icache_line_ram #(.DEPTH(SETS), .WIDTH(LINE_W), .AW(SET_W)) u_ram (
      .clk(clk), .we(last && (miss_way_q == WAY_W'(w))),
      .waddr(line_base_q[SET_W-1:0]), .wdata(mem_line_i),
      .raddr(set_idx), .rdata(rd_line[w])
    );
  end

  always_comb begin
    hit_line = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_line = hit_line | rd_line[w];
    src_line = last ? mem_line_i : hit_line;
    word = '0;
    for (int i = 0; i < WORDS; i++)
      if (wsel == WSEL_W'(i)) word = src_line[i*INSTR_W +: INSTR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_valid_o <= 1'b0;
      hit_pulse_o   <= 1'b0;
      miss_pulse_o  <= 1'b0;
      instr_o       <= '0;
    end else begin
      instr_valid_o <= accept;
      hit_pulse_o   <= accept && !busy;
      miss_pulse_o  <= accept && busy;
      if (accept) instr_o <= word;
    end
  end

  // R3: a stalled request stays unchanged
  a_r3_request_held: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (fetch_valid_i && $stable(fetch_addr_i)));
  // R3: a lookup that misses while idle starts a refill
  a_r3_miss_starts_fill: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_i && !busy && !any_hit) |=> busy);
  // R10: one pulse per delivery, never both
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    !(hit_pulse_o && miss_pulse_o));
  // R10: a delivery needs a request in the previous cycle
  a_r10_delivery_has_request: assert property (@(posedge clk) disable iff (rst)
    instr_valid_o |-> $past(fetch_valid_i));
endmodule

// File: tb/icache_ctrl_tb.sv
`timescale 1ns/1ps
module icache_ctrl_tb;
  localparam int P = 5;

  typedef struct packed {
    logic [31:0] data;
    logic        miss;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fv [2];
  logic [31:0]  fa [2];
  logic         stall [2];
  logic         iv [2];
  logic [31:0]  ins [2];
  logic         hp [2];
  logic         mp [2];
  logic         mrd [2];
  logic [31:0]  ma [2];
  logic [127:0] ml [2];

  int   checks = 0;
  int   fails  = 0;
  exp_t q0[$];
  exp_t q1[$];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [127:0] line_of(input logic [31:0] base);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[i*32 +: 32] = word_at(base + 32'(i * 4));
    return l;
  endfunction

  assign ml[0] = line_of(ma[0]);
  assign ml[1] = line_of(ma[1]);

  icache_ctrl #(.WAYS(1), .MISS_PENALTY(P)) u_dut (
    .clk(clk), .rst(rst), .fetch_valid_i(fv[0]), .fetch_addr_i(fa[0]),
    .stall_o(stall[0]), .instr_valid_o(iv[0]), .instr_o(ins[0]),
    .hit_pulse_o(hp[0]), .miss_pulse_o(mp[0]), .mem_rd_o(mrd[0]),
    .mem_addr_o(ma[0]), .mem_line_i(ml[0])
  );

  icache_ctrl #(.WAYS(2), .MISS_PENALTY(P)) u_dut_2w (
    .clk(clk), .rst(rst), .fetch_valid_i(fv[1]), .fetch_addr_i(fa[1]),
    .stall_o(stall[1]), .instr_valid_o(iv[1]), .instr_o(ins[1]),
    .hit_pulse_o(hp[1]), .miss_pulse_o(mp[1]), .mem_rd_o(mrd[1]),
    .mem_addr_o(ma[1]), .mem_line_i(ml[1])
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // driver: presents one fetch, measures its stall, pushes the expectation
  task automatic fetch(input int m, input logic [31:0] a, input bit exp_miss,
                       input string req);
    int   n;
    bit   done;
    exp_t e;
    @(negedge clk);
    fv[m] = 1'b1;
    fa[m] = a;
    n = 0;
    done = 1'b0;
    while (!done) begin
      #1;
      if (!stall[m] || n > 40) begin
        done = 1'b1;
      end else begin
        if (n == 1)
          check(mrd[m] && ma[m] == {a[31:4], 4'h0}, "R4", "refill line address",
                ma[m], {a[31:4], 4'h0});
        n++;
        @(negedge clk);
      end
    end
    check(n == (exp_miss ? P : 0), exp_miss ? "R3" : "R2",
          $sformatf("%s stall cycles for %h", req, a), 32'(n),
          exp_miss ? 32'(P) : 32'd0);
    e.data = word_at({a[31:2], 2'b00});
    e.miss = exp_miss;
    if (m == 0) q0.push_back(e); else q1.push_back(e);
    @(negedge clk);
    fv[m] = 1'b0;
  endtask

  // monitor: compares every delivery with the front of its queue
  task automatic observe(input int m);
    exp_t e;
    if (iv[m]) begin
      if ((m == 0 && q0.size() == 0) || (m == 1 && q1.size() == 0)) begin
        check(1'b0, "R10", "delivery without a request", 32'd1, 32'd0);
      end else begin
        e = (m == 0) ? q0.pop_front() : q1.pop_front();
        check(ins[m] == e.data, "R4", "instruction word", ins[m], e.data);
        check(mp[m] == e.miss && hp[m] == !e.miss, "R10", "hit/miss pulse kind",
              {30'd0, mp[m], hp[m]}, {30'd0, e.miss, !e.miss});
      end
    end else begin
      check(!hp[m] && !mp[m], "R10", "pulse without delivery",
            {30'd0, mp[m], hp[m]}, 32'd0);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      observe(0);
      observe(1);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 32'd1, 32'd0);
    summary();
  end

  initial begin
    fv[0] = 1'b0; fv[1] = 1'b0;
    fa[0] = '0;   fa[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      check(!iv[m] && !hp[m] && !mp[m], "R1", "outputs after reset",
            {29'd0, iv[m], hp[m], mp[m]}, 32'd0);

    // direct-mapped build
    fetch(0, 32'h108, 1'b1, "R1 cold line");
    fetch(0, 32'h10C, 1'b0, "R5 same line");
    fetch(0, 32'h100, 1'b0, "R5 line start");
    fetch(0, 32'h11C, 1'b1, "R1 next line");
    fetch(0, 32'h110, 1'b0, "R5 resident");
    fetch(0, 32'h218, 1'b1, "R6 conflict");
    fetch(0, 32'h110, 1'b1, "R6 evicted");
    fetch(0, 32'h218, 1'b1, "R6 evicted again");
    fetch(0, 32'h108, 1'b0, "R6 other index kept");

    // two-way build
    fetch(1, 32'h108, 1'b1, "R1 cold line");
    fetch(1, 32'h10C, 1'b0, "R5 same line");
    fetch(1, 32'h110, 1'b1, "R7 set1 first");
    fetch(1, 32'h218, 1'b1, "R9 invalid way");
    fetch(1, 32'h110, 1'b0, "R9 kept");
    fetch(1, 32'h218, 1'b0, "R7 both resident");
    fetch(1, 32'h310, 1'b1, "R8 third line");
    fetch(1, 32'h218, 1'b0, "R8 recent kept");
    fetch(1, 32'h110, 1'b1, "R8 older evicted");
    fetch(1, 32'h218, 1'b0, "R8 recent kept");
    fetch(1, 32'h314, 1'b1, "R8 lru replaced");
    fetch(1, 32'h108, 1'b0, "R7 other set kept");

    // reset invalidates every line
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    fetch(0, 32'h104, 1'b1, "R1 after reset");
    fetch(1, 32'h21C, 1'b1, "R1 after reset");

    repeat (3) @(negedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R10", "undelivered fetches",
          32'(q0.size() + q1.size()), 32'd0);
    summary();
  end
endmodule